// File: doc/BRIEF.md
# Receive Frame Page Packer

This block sits between a receive MAC and a paged packet memory. For each incoming frame it takes a start pulse carrying the frame length, then the frame as a stream of bytes under a valid/ready handshake. It asks an external allocator for a free page and then fills that page with a fixed layout: a two-byte status word, a two-byte byte count, the payload (short frames zero-padded to the minimum size), an optional CRC-32, one tail byte and a control byte. When the last byte is stored, it pushes the page number onto the receive queue and pulses the receive interrupt.

Frames that cannot be stored are still consumed from the stream, so the source never stalls on them. A frame is not stored when reception is off, when the soft-reset control is on, when the resulting byte count would not fit a page, or when the allocator has no page to give. The CRC is generated inside the block, one byte per clock, and is placed on a 16-bit boundary before an odd final byte.

Top module: `rx_frame_packer`

## Requirements
- R1: A frame started while `rxEnable` is low or `softReset` is high is consumed in full from the byte stream, with no memory write, no allocation request and no queue push.
- R2: The byte count stored little-endian at page offsets 2 and 3 equals max(64, length rounded down to even) + 6, plus 4 when `stripCrc` is low; the total number of bytes written to the page equals this count.
- R3: A frame whose byte count exceeds 2048 is consumed with no memory write and no push; a count of exactly 2048 is stored.
- R4: The status word stored little-endian at offsets 0 and 1 has bit 11 (0x0800) set when the length exceeds 1518 and bit 12 (0x1000) set when the length is odd; all other bits are zero.
- R5: Payload bytes are stored in arrival order from offset 4; a frame shorter than 64 bytes keeps all its bytes, including an odd last one, in place and is followed by zero bytes up to 64 payload bytes.
- R6: With `stripCrc` low, the CRC-32 (reflected polynomial 0xEDB88320, all-ones preset, final inversion) over the stored payload including padding and any odd last byte is written least significant byte first right after the even payload; with `stripCrc` high no CRC bytes are written.
- R7: For a frame of 64 bytes or more with odd length, the odd last byte follows the CRC (or the payload) and is followed by control byte 0x60; otherwise a zero byte follows, then control byte 0x40.
- R8: `allocReq` stays high until `allocAck`; a grant with `allocOk` high stores the frame in page `allocPage`, a grant with `allocOk` low drops the frame with no write and no push.
- R9: After the control byte is written, `rxqPush` and `rcvSet` pulse together for one cycle with `rxqPage` equal to the stored page, and `inReady` and `frameReady` are low in that cycle.
- R10: After reset `frameReady` is high and `inReady`, `allocReq`, `memWe`, `rxqPush` and `rcvSet` are low.
- R11: A start pulse is taken only while `frameReady` is high; `allocReq`, `inReady`, `rxqPush` and `frameReady` are never high together in pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Reception allowed, sampled at start |
| softReset | input | 1 | Soft-reset control, refuses frames when high, sampled at start |
| stripCrc | input | 1 | Omit the generated CRC, sampled at start |
| frameReady | output | 1 | Idle, a start pulse is accepted |
| inStart | input | 1 | Start of frame, qualifies `inLen` |
| inLen | input | 12 | Frame length in bytes (at least 1) |
| inValid | input | 1 | Byte on `inData` is valid |
| inReady | output | 1 | Byte is taken on this clock when valid |
| inData | input | 8 | Frame byte |
| allocReq | output | 1 | Page request to the allocator |
| allocAck | input | 1 | Allocator answer strobe |
| allocOk | input | 1 | Answer carries a page |
| allocPage | input | 2 | Granted page number |
| memWe | output | 1 | Page memory byte write |
| memAddr | output | 13 | Page number and byte offset |
| memData | output | 8 | Byte written |
| rxqPush | output | 1 | Push `rxqPage` onto the receive queue |
| rxqPage | output | 2 | Page of the completed frame |
| rcvSet | output | 1 | Receive interrupt set pulse |

## Verification
The assertions assume a start pulse only while `frameReady` is high, a frame length of at least one byte, exactly `inLen` bytes offered per frame, and an allocator that answers each request with a single-cycle `allocAck`. The bench drives one frame at a time, waits for `frameReady` before every start, offers exactly the announced number of bytes and models the allocator with a one-cycle answer, so every stimulus stays inside those assumptions. Refused and dropped frames are checked at the memory and queue ports by counting writes and pushes across the frame.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  typedef enum logic [2:0] {
    W_HDR,
    W_DATA,
    W_PAD,
    W_CRC,
    W_TAIL,
    W_CTRL
  } wrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   frameLoad;
    logic   pageLoad;
    logic   wrEn;
    wrSel_e wrSel;
    logic [1:0] idx;
    logic   crcStep;
    logic   holdOdd;
  } pkCtrl_t;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] frameCount(input logic [15:0] len, input logic strip,
                                             input int minFrame);
    logic [15:0] body;
    body = (len < 16'(minFrame)) ? 16'(minFrame) : {len[15:1], 1'b0};
    return body + 16'd6 + (strip ? 16'd0 : 16'd4);
  endfunction

endpackage

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             softReset,
  input  logic             stripCrc,
  input  logic             inStart,
  input  logic [LEN_W-1:0] inLen,
  input  logic             inValid,
  output logic             inReady,
  output logic             frameReady,
  output logic             allocReq,
  input  logic             allocAck,
  input  logic             allocOk,
  output logic             rxqPush,
  output logic             rcvSet,
  output pkCtrl_t          ctrl
);

  localparam int PAD_W = $clog2(MIN_FRAME + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DRAIN, S_ALLOC, S_HDR, S_DATA, S_PAD, S_CRC, S_TAIL, S_CTRL, S_COMMIT
  } state_e;

  state_e           state, stateNxt;
  logic [LEN_W-1:0] remain;
  logic [PAD_W-1:0] padLeft;
  logic [1:0]       idx;
  logic             crcOn;
  logic             oddTail;

  logic [15:0] startCount;
  logic        startShort;
  logic        startDrop;
  logic        accept;
  logic        lastByte;
  state_e      afterPay;

  always_comb begin
    startCount = frameCount(16'(inLen), stripCrc, MIN_FRAME);
    startShort = inLen < LEN_W'(MIN_FRAME);
    startDrop  = !rxEnable || softReset || (32'(startCount) > PAGE_BYTES);
    accept     = inReady && inValid;
    lastByte   = remain == LEN_W'(1);
    afterPay   = crcOn ? S_CRC : S_TAIL;
  end

  always_comb begin
    stateNxt   = state;
    ctrl       = '0;
    ctrl.wrSel = W_HDR;
    ctrl.idx   = idx;
    inReady    = 1'b0;
    frameReady = 1'b0;
    allocReq   = 1'b0;
    rxqPush    = 1'b0;
    rcvSet     = 1'b0;
    unique case (state)
      S_IDLE: begin
        frameReady = 1'b1;
        if (inStart) begin
          ctrl.frameLoad = 1'b1;
          if (inLen == '0)    stateNxt = S_IDLE;
          else if (startDrop) stateNxt = S_DRAIN;
          else                stateNxt = S_ALLOC;
        end
      end
      S_DRAIN: begin
        inReady = 1'b1;
        if (accept && lastByte) stateNxt = S_IDLE;
      end
      S_ALLOC: begin
        allocReq = 1'b1;
        if (allocAck) begin
          if (allocOk) begin
            ctrl.pageLoad = 1'b1;
            stateNxt      = S_HDR;
          end else begin
            stateNxt = S_DRAIN;
          end
        end
      end
      S_HDR: begin
        ctrl.wrEn = 1'b1;
        if (idx == 2'd3) stateNxt = S_DATA;
      end
      S_DATA: begin
        inReady    = 1'b1;
        ctrl.wrSel = W_DATA;
        if (accept) begin
          ctrl.crcStep = 1'b1;
          if (lastByte && oddTail) ctrl.holdOdd = 1'b1;
          else                     ctrl.wrEn    = 1'b1;
          if (lastByte) stateNxt = (padLeft != '0) ? S_PAD : afterPay;
        end
      end
      S_PAD: begin
        ctrl.wrSel   = W_PAD;
        ctrl.wrEn    = 1'b1;
        ctrl.crcStep = 1'b1;
        if (padLeft == PAD_W'(1)) stateNxt = afterPay;
      end
      S_CRC: begin
        ctrl.wrSel = W_CRC;
        ctrl.wrEn  = 1'b1;
        if (idx == 2'd3) stateNxt = S_TAIL;
      end
      S_TAIL: begin
        ctrl.wrSel = W_TAIL;
        ctrl.wrEn  = 1'b1;
        stateNxt   = S_CTRL;
      end
      S_CTRL: begin
        ctrl.wrSel = W_CTRL;
        ctrl.wrEn  = 1'b1;
        stateNxt   = S_COMMIT;
      end
      S_COMMIT: begin
        rxqPush  = 1'b1;
        rcvSet   = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      remain  <= '0;
      padLeft <= '0;
      idx     <= '0;
      crcOn   <= 1'b0;
      oddTail <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && inStart) begin
        remain  <= inLen;
        padLeft <= startShort ? PAD_W'(LEN_W'(MIN_FRAME) - inLen) : '0;
        crcOn   <= !stripCrc;
        oddTail <= inLen[0] && !startShort;
        idx     <= '0;
      end
      if (accept) remain <= remain - LEN_W'(1);
      if (state == S_PAD) padLeft <= padLeft - PAD_W'(1);
      if (state == S_HDR || state == S_CRC) idx <= idx + 2'd1;
    end
  end

  // R8: a pending page request stays up until answered
  assert_alloc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    allocReq && !allocAck |=> allocReq);

  // R9: the commit cycle takes neither bytes nor a new frame
  assert_commit_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxqPush |-> !inReady && !frameReady);

  // R11: handshake phases never overlap
  assert_phase_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({allocReq, inReady, rxqPush, frameReady}));

  // R1: a refused frame never reaches the allocator
  assert_refuse_no_alloc_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameReady && inStart && (!rxEnable || softReset) |=> !allocReq);

endmodule

// File: rtl/rxpk_datapath.sv
module rxpk_datapath
  import rxpk_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_STD    = 1518
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pkCtrl_t                   ctrl,
  input  logic [LEN_W-1:0]          inLen,
  input  logic                      stripCrc,
  input  logic [7:0]                inData,
  input  logic [$clog2(PAGES)-1:0]  allocPage,
  output logic                      memWe,
  output logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] memAddr,
  output logic [7:0]                memData,
  output logic [$clog2(PAGES)-1:0]  rxqPage
);

  localparam int PAGE_W = $clog2(PAGES);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam logic [15:0] ST_TOO_LONG = 16'h0800;
  localparam logic [15:0] ST_ODD      = 16'h1000;
  localparam logic [7:0]  CTL_EVEN    = 8'h40;
  localparam logic [7:0]  CTL_ODD     = 8'h60;

  logic [15:0]       statusW;
  logic [15:0]       countW;
  logic [31:0]       crcR;
  logic [7:0]        oddByte;
  logic              tailOdd;
  logic [PAGE_W-1:0] pageR;
  logic [OFF_W-1:0]  off;
  logic [31:0]       crcOut;
  logic [7:0]        crcIn;

  always_comb begin
    crcOut = ~crcR;
    crcIn  = (ctrl.wrSel == W_PAD) ? 8'h00 : inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusW <= '0;
      countW  <= '0;
      crcR    <= '1;
      oddByte <= '0;
      tailOdd <= 1'b0;
      pageR   <= '0;
      off     <= '0;
    end else begin
      if (ctrl.frameLoad) begin
        statusW <= ((inLen > LEN_W'(MAX_STD)) ? ST_TOO_LONG : 16'h0) |
                   (inLen[0] ? ST_ODD : 16'h0);
        countW  <= frameCount(16'(inLen), stripCrc, MIN_FRAME);
        tailOdd <= inLen[0] && (inLen >= LEN_W'(MIN_FRAME));
        crcR    <= '1;
        off     <= '0;
      end
      if (ctrl.pageLoad) pageR <= allocPage;
      if (ctrl.crcStep) crcR <= crcByte(crcR, crcIn);
      if (ctrl.holdOdd) oddByte <= inData;
      if (ctrl.wrEn) off <= off + OFF_W'(1);
    end
  end

  always_comb begin
    memData = 8'h00;
    unique case (ctrl.wrSel)
      W_HDR: begin
        unique case (ctrl.idx)
          2'd0: memData = statusW[7:0];
          2'd1: memData = statusW[15:8];
          2'd2: memData = countW[7:0];
          default: memData = countW[15:8];
        endcase
      end
      W_DATA: memData = inData;
      W_PAD:  memData = 8'h00;
      W_CRC:  memData = crcOut[8*ctrl.idx +: 8];
      W_TAIL: memData = tailOdd ? oddByte : 8'h00;
      W_CTRL: memData = tailOdd ? CTL_ODD : CTL_EVEN;
      default: memData = 8'h00;
    endcase
  end

  assign memWe   = ctrl.wrEn;
  assign memAddr = {pageR, off};
  assign rxqPage = pageR;

  // R5: back-to-back writes land on consecutive offsets
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrEn && $past(ctrl.wrEn) |-> off == OFF_W'($past(off) + OFF_W'(1)));

  // R6: the checksum is frozen while its bytes are emitted
  assert_crc_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrEn && ctrl.wrSel == W_CRC && $past(ctrl.wrEn && ctrl.wrSel == W_CRC)
    |-> $stable(crcR));

  // R2: the page never changes while a frame is being written
  assert_page_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrEn && $past(ctrl.wrEn) |-> $stable(pageR));

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxpk_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_STD    = 1518
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rxEnable,
  input  logic                      softReset,
  input  logic                      stripCrc,
  output logic                      frameReady,
  input  logic                      inStart,
  input  logic [LEN_W-1:0]          inLen,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [7:0]                inData,
  output logic                      allocReq,
  input  logic                      allocAck,
  input  logic                      allocOk,
  input  logic [$clog2(PAGES)-1:0]  allocPage,
  output logic                      memWe,
  output logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] memAddr,
  output logic [7:0]                memData,
  output logic                      rxqPush,
  output logic [$clog2(PAGES)-1:0]  rxqPage,
  output logic                      rcvSet
);

  pkCtrl_t ctrl;

  rxpk_ctrl #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MIN_FRAME(MIN_FRAME)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxEnable(rxEnable), .softReset(softReset), .stripCrc(stripCrc),
    .inStart(inStart), .inLen(inLen), .inValid(inValid), .inReady(inReady),
    .frameReady(frameReady),
    .allocReq(allocReq), .allocAck(allocAck), .allocOk(allocOk),
    .rxqPush(rxqPush), .rcvSet(rcvSet),
    .ctrl(ctrl)
  );

  rxpk_datapath #(
    .LEN_W(LEN_W), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES),
    .MIN_FRAME(MIN_FRAME), .MAX_STD(MAX_STD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inLen(inLen), .stripCrc(stripCrc), .inData(inData),
    .allocPage(allocPage),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .rxqPage(rxqPage)
  );

endmodule

// File: tb/test_rx_frame_packer.sv
`timescale 1ns/1ps
module test_rx_frame_packer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, softReset = 1'b0, stripCrc = 1'b0;
  logic frameReady, inReady, allocReq, memWe, rxqPush, rcvSet;
  logic inStart = 1'b0, inValid = 1'b0;
  logic [11:0] inLen = '0;
  logic [7:0] inData = '0;
  logic allocAck = 1'b0, allocOk = 1'b0;
  logic [1:0] allocPage = '0;
  logic [12:0] memAddr;
  logic [7:0] memData;
  logic [1:0] rxqPage;

  always #2.5 clk = ~clk;

  rx_frame_packer i_rx_frame_packer (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .softReset(softReset),
    .stripCrc(stripCrc), .frameReady(frameReady), .inStart(inStart), .inLen(inLen),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .allocReq(allocReq), .allocAck(allocAck), .allocOk(allocOk), .allocPage(allocPage),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .rxqPush(rxqPush), .rxqPage(rxqPage), .rcvSet(rcvSet)
  );

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // allocator model: one-cycle answer
  logic denyAlloc = 1'b0;
  logic [1:0] nextPage = '0;
  always @(posedge clk) begin
    allocAck <= allocReq && !allocAck;
    allocOk  <= !denyAlloc;
    allocPage <= nextPage;
    if (allocReq && !allocAck && !denyAlloc) nextPage <= nextPage + 2'd1;
  end

  // expected page image
  logic [7:0] expImg [0:2047];
  typedef struct packed { logic [1:0] page; logic [15:0] len; } expItem_t;
  expItem_t expQ[$];

  function automatic logic [7:0] frameByte(input int seed, input int i);
    return 8'(seed + i * 37 + (i >> 5));
  endfunction

  function automatic int buildImage(input int len, input int seed, input bit strip);
    int dataLen, span, p;
    logic [31:0] c;
    logic [7:0] d;
    logic [15:0] st, cnt;
    bit oddLong;
    dataLen = (len < 64) ? 64 : (len & ~1);
    span    = (len < 64) ? 64 : len;
    cnt     = 16'(dataLen + 6 + (strip ? 0 : 4));
    st      = ((len > 1518) ? 16'h0800 : 16'h0) | ((len % 2 == 1) ? 16'h1000 : 16'h0);
    expImg[0] = st[7:0];  expImg[1] = st[15:8];
    expImg[2] = cnt[7:0]; expImg[3] = cnt[15:8];
    for (int i = 0; i < dataLen; i++) expImg[4 + i] = (i < len) ? frameByte(seed, i) : 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < span; i++) begin
      d = (i < len) ? frameByte(seed, i) : 8'h00;
      for (int k = 0; k < 8; k++) begin
        bit fb;
        fb = c[0] ^ d[k];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    c = ~c;
    p = 4 + dataLen;
    if (!strip) begin
      for (int k = 0; k < 4; k++) expImg[p + k] = c[8*k +: 8];
      p += 4;
    end
    oddLong = (len % 2 == 1) && (len >= 64);
    expImg[p]     = oddLong ? frameByte(seed, len - 1) : 8'h00;
    expImg[p + 1] = oddLong ? 8'h60 : 8'h40;
    return p + 2;
  endfunction

  // monitor / scoreboard
  int writeCnt = 0, pushCnt = 0;
  int fWrites = 0, fBad = 0, badOff = 0;
  logic [7:0] badAct = '0, badExp = '0;
  logic [1:0] wrPage = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        writeCnt++;
        fWrites++;
        wrPage = memAddr[12:11];
        if (memData !== expImg[memAddr[10:0]] && fBad == 0) begin
          badOff = int'(memAddr[10:0]); badAct = memData; badExp = expImg[memAddr[10:0]];
        end
        if (memData !== expImg[memAddr[10:0]]) fBad++;
      end
      if (rxqPush) begin
        expItem_t it;
        pushCnt++;
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected push", 1, 0);
        end else begin
          it = expQ.pop_front();
          check(rxqPage == it.page, "R8 queued page", rxqPage, it.page);
          check(wrPage == it.page, "R8 written page", wrPage, it.page);
          check(rcvSet == 1'b1, "R9 interrupt with push", rcvSet, 1);
          check(!inReady && !frameReady, "R9 ready low at commit", {inReady, frameReady}, 0);
          check(fWrites == int'(it.len), "R2 bytes written equals count", fWrites, it.len);
          check(fBad == 0, "R4 R5 R6 R7 page image byte", badAct, badExp);
          if (fBad != 0) $display("  first bad offset %0d", badOff);
        end
        fWrites = 0; fBad = 0;
      end
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (!frameReady) @(negedge clk);
  endtask

  // driver: one frame, expected item pushed when the frame must be stored
  task automatic runFrame(input int len, input int seed, input bit en, input bit sr,
                          input bit strip, input bit deny, input bit expStore, input string tag);
    int w0, p0, cnt;
    waitIdle();
    rxEnable = en; softReset = sr; stripCrc = strip; denyAlloc = deny;
    cnt = buildImage(len, seed, strip);
    if (expStore) expQ.push_back('{page: nextPage, len: 16'(cnt)});
    w0 = writeCnt; p0 = pushCnt;
    inStart = 1'b1; inLen = 12'(len);
    @(negedge clk);
    inStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inData = frameByte(seed, i);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    waitIdle();
    repeat (2) @(negedge clk);
    if (expStore) begin
      check(pushCnt == p0 + 1, {tag, " frame stored"}, pushCnt - p0, 1);
    end else begin
      check(writeCnt == w0, {tag, " dropped frame writes nothing"}, writeCnt - w0, 0);
      check(pushCnt == p0, {tag, " dropped frame not queued"}, pushCnt - p0, 0);
    end
    denyAlloc = 1'b0;
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) expImg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(frameReady == 1'b1, "R10 frameReady after reset", frameReady, 1);
    check({inReady, allocReq, memWe, rxqPush, rcvSet} == 5'b0, "R10 outputs idle after reset",
          {inReady, allocReq, memWe, rxqPush, rcvSet}, 0);

    runFrame(100,  3, 1, 0, 0, 0, 1, "R2 R6 even with CRC");
    runFrame(101,  9, 1, 0, 0, 0, 1, "R7 odd long with CRC");
    runFrame(33,  17, 1, 0, 0, 0, 1, "R5 short odd padded");
    runFrame(60,  21, 1, 0, 1, 0, 1, "R6 short even stripped");
    runFrame(1600, 5, 1, 0, 1, 0, 1, "R4 too-long status");
    runFrame(2038, 7, 1, 0, 0, 0, 1, "R3 count exactly 2048");
    runFrame(2040, 8, 1, 0, 0, 0, 0, "R3 count over 2048");
    runFrame(80,  11, 0, 0, 0, 0, 0, "R1 receive disabled");
    runFrame(80,  12, 1, 1, 0, 0, 0, "R1 soft reset set");
    runFrame(90,  13, 1, 0, 0, 1, 0, "R8 no free page");
    runFrame(65,  14, 1, 0, 1, 0, 1, "R7 odd long stripped");
    runFrame(64,  15, 1, 0, 0, 0, 1, "R11 minimum size after drops");
    runFrame(1519, 2, 1, 0, 0, 0, 1, "R4 odd and too long");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R9 every stored frame queued", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule